// File: doc/BRIEF.md
# Sampling Converter Control and Result Registers

This block sits on a processor's register bus in front of a 64-channel, 12-bit sampling converter. Software sees two 16-bit words: a control and status word at word index 0 (byte offset 0) and a result word at word index 1 (byte offset 2). A conversion starts in one of three ways: software writes the go bit, a pulse arrives from the associated clock module on its overflow line, or a pulse arrives on the external trigger line. Each trigger line has its own enable bit in the control word.

The converter itself sits outside the block. The block drives a request level and the selected channel to it. The converter answers with a one-cycle acknowledge that carries the 12-bit sample and the channel's 4-bit type code. The block captures the sample into the result word. It can replace the sample with forced maintenance values, and it can tag the upper four result bits with the channel code. Two flags report events: a completion flag, and an error flag for an illegal restart or an overrun. Each flag drives its own level interrupt request and has its own enable. The two requests map to two vectors, the base vector and the base vector plus 4.

Control word bits: 15 error flag, 14 error interrupt enable, 13:8 channel select, 7 completion flag, 6 completion interrupt enable, 5 clock-overflow trigger enable, 4 external trigger enable, 3 code-tag enable, 2 maintenance, 1 channel-absent (read-only), 0 go/busy.

Top module: `adc_ctrl_regs`

## Requirements
- R1: Writing the control word with bit 0 = 1 while idle starts a conversion. From the next cycle, bit 0 reads 1 and conv_req is high until the cycle after the converter's acknowledge. Then bit 0 reads 0.
- R2: A start request of any kind while a conversion is in progress sets the error flag (bit 15) and does not start another conversion.
- R3: If a result is captured while the completion flag (bit 7) is still 1 and the result word is not being read in that cycle, the error flag is set (overrun).
- R4: Capturing a result sets the completion flag. A read strobe on the result word clears it, unless a capture happens in the same cycle.
- R5: irq_done is high exactly while bits 7 and 6 are both 1. irq_err is high exactly while bits 15 and 14 are both 1.
- R6: With maintenance (bit 2) set when a conversion starts, channel 0 stores sample 0 and channel 1 stores 4095. Any other channel stores the converter value.
- R7: Result word bits 11:0 hold the last sample. Bits 15:12 hold the converter's channel code if bit 3 was set when that conversion started, and 0 otherwise.
- R8: Bit 1 reads 1 whenever the channel select is not below NUM_CHAN, and 0 otherwise.
- R9: A rising edge on clk_ovf_in (enabled by bit 5) or on ext_trig_in (enabled by bit 4) starts a conversion. Bit 0 reads 1 after the third rising clock edge that samples the line high. A disabled line has no effect.
- R10: After reset, both words read 0 and both interrupt requests and conv_req are low.
- R11: A control word write loads bits 15:2 as written, so writing 0 to bit 15 or bit 7 clears that flag. Bit 1 is never written.
- R12: conv_chan holds the channel selected at the start of the conversion for as long as conv_req is high, even if the control word is rewritten.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Write strobe, one cycle |
| bus_rd | input | 1 | Read strobe, one cycle (side effect on result word) |
| bus_addr | input | 1 | Word index: 0 control, 1 result |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data of the addressed word |
| clk_ovf_in | input | 1 | Clock-module overflow pulse, asynchronous |
| ext_trig_in | input | 1 | External trigger pulse, asynchronous |
| conv_req | output | 1 | Conversion request level to the converter |
| conv_chan | output | 6 | Channel being converted |
| conv_ack | input | 1 | Converter done, one cycle |
| conv_data | input | 12 | Converter sample, valid with conv_ack |
| conv_code | input | 4 | Channel type code, valid with conv_ack |
| irq_done | output | 1 | Completion interrupt request (base vector) |
| irq_err | output | 1 | Error interrupt request (base vector + 4) |

## Verification
The properties assume that the converter raises conv_ack only while conv_req is high, and for one cycle at a time. They also assume that the bus never asserts read and write in the same cycle. The bench's converter model counts request cycles and answers exactly once per request. The random stimulus picks either a write or a read for each cycle, never both. Trigger lines are held high for at least one full clock so that the synchroniser sees each pulse.

// File: rtl/adc_ctrl_pkg.sv
package adc_ctrl_pkg;
  localparam int WORD_W = 16;
  localparam int CHAN_W = 6;
  localparam int SAMP_W = 12;
  localparam int CODE_W = 4;

  // control word bit positions (software-visible layout)
  localparam int B_ERR   = 15;
  localparam int B_ERRIE = 14;
  localparam int B_CHLO  = 8;
  localparam int B_DONE  = 7;
  localparam int B_IE    = 6;
  localparam int B_CLKEN = 5;
  localparam int B_EXTEN = 4;
  localparam int B_IDEN  = 3;
  localparam int B_MAINT = 2;

  typedef struct packed {
    logic              errie;
    logic [CHAN_W-1:0] chan;
    logic              ie;
    logic              clken;
    logic              exten;
    logic              iden;
    logic              maint;
  } ctl_cfg_t;
endpackage

// File: rtl/adc_trig_sync.sv
module adc_trig_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic din,
  output logic rise
);
  localparam int LEN = STAGES + 1;

  logic [LEN-1:0] sh_q;
  logic [LEN-1:0] sh_d;

  always_comb begin
    sh_d = {sh_q[LEN-2:0], din};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sh_q <= '0;
    else        sh_q <= sh_d;
  end

  assign rise = sh_q[STAGES-1] & ~sh_q[STAGES];
endmodule

// File: rtl/adc_conv_seq.sv
module adc_conv_seq
  import adc_ctrl_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_req,
  input  ctl_cfg_t          cfg_next,
  input  logic              conv_ack,
  input  logic [SAMP_W-1:0] conv_data,
  input  logic [CODE_W-1:0] conv_code,
  output logic              busy,
  output logic              capture,
  output logic              start_bad,
  output logic [CHAN_W-1:0] lat_chan,
  output logic [WORD_W-1:0] res_word
);
  localparam logic [CHAN_W-1:0] CH_ZERO = CHAN_W'(0);
  localparam logic [CHAN_W-1:0] CH_ONE  = CHAN_W'(1);

  logic              busy_q, busy_d;
  logic              maint_q, maint_d, iden_q, iden_d;
  logic [CHAN_W-1:0] chan_q, chan_d;
  logic [WORD_W-1:0] res_q, res_d;
  logic              start_ok;
  logic [SAMP_W-1:0] samp;

  assign capture   = conv_ack & busy_q;
  assign start_ok  = start_req & ~busy_q;
  assign start_bad = start_req & busy_q;

  always_comb begin
    if (maint_q && chan_q == CH_ZERO)     samp = '0;
    else if (maint_q && chan_q == CH_ONE) samp = '1;
    else                                  samp = conv_data;
  end

  always_comb begin
    busy_d  = busy_q;
    chan_d  = chan_q;
    maint_d = maint_q;
    iden_d  = iden_q;
    res_d   = res_q;
    if (start_ok) begin
      busy_d  = 1'b1;
      chan_d  = cfg_next.chan;
      maint_d = cfg_next.maint;
      iden_d  = cfg_next.iden;
    end
    if (capture) begin
      busy_d = 1'b0;
      res_d  = {(iden_q ? conv_code : CODE_W'(0)), samp};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q  <= 1'b0;
      chan_q  <= '0;
      maint_q <= 1'b0;
      iden_q  <= 1'b0;
      res_q   <= '0;
    end else begin
      if (start_ok || capture) busy_q <= busy_d;
      if (start_ok) begin
        chan_q  <= chan_d;
        maint_q <= maint_d;
        iden_q  <= iden_d;
      end
      if (capture) res_q <= res_d;
    end
  end

  assign busy     = busy_q;
  assign lat_chan = chan_q;
  assign res_word = res_q;
endmodule

// File: rtl/adc_ctrl_csr.sv
module adc_ctrl_csr
  import adc_ctrl_pkg::*;
#(
  parameter int NUM_CHAN = 64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic              bus_addr,
  input  logic [WORD_W-1:0] bus_wdata,
  input  logic              capture,
  input  logic              start_bad,
  input  logic              busy,
  input  logic [WORD_W-1:0] res_word,
  output ctl_cfg_t          cfg_q,
  output ctl_cfg_t          cfg_d,
  output logic              done_q,
  output logic              err_q,
  output logic              sw_go,
  output logic [WORD_W-1:0] bus_rdata
);
  localparam logic [CHAN_W:0] CH_LIMIT = (CHAN_W+1)'(NUM_CHAN);

  logic wr_ctl, rd_res, done_d, err_d, upd, nxc;
  logic unused_ro_bit;

  assign wr_ctl        = bus_wr & ~bus_addr;
  assign rd_res        = bus_rd & bus_addr;
  assign sw_go         = wr_ctl & bus_wdata[0];
  assign unused_ro_bit = bus_wdata[1];

  always_comb begin
    cfg_d  = cfg_q;
    done_d = done_q;
    err_d  = err_q;
    if (wr_ctl) begin
      cfg_d.errie = bus_wdata[B_ERRIE];
      cfg_d.chan  = bus_wdata[B_CHLO +: CHAN_W];
      cfg_d.ie    = bus_wdata[B_IE];
      cfg_d.clken = bus_wdata[B_CLKEN];
      cfg_d.exten = bus_wdata[B_EXTEN];
      cfg_d.iden  = bus_wdata[B_IDEN];
      cfg_d.maint = bus_wdata[B_MAINT];
      done_d      = bus_wdata[B_DONE];
      err_d       = bus_wdata[B_ERR];
    end
    if (rd_res) done_d = 1'b0;
    if (capture) begin
      if (done_q && !rd_res) err_d = 1'b1;
      done_d = 1'b1;
    end
    if (start_bad) err_d = 1'b1;
  end

  assign upd = wr_ctl | rd_res | capture | start_bad;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q  <= '0;
      done_q <= 1'b0;
      err_q  <= 1'b0;
    end else if (upd) begin
      cfg_q  <= cfg_d;
      done_q <= done_d;
      err_q  <= err_d;
    end
  end

  assign nxc = {1'b0, cfg_q.chan} >= CH_LIMIT;

  always_comb begin
    if (bus_addr) bus_rdata = res_word;
    else bus_rdata = {err_q, cfg_q.errie, cfg_q.chan, done_q, cfg_q.ie,
                      cfg_q.clken, cfg_q.exten, cfg_q.iden, cfg_q.maint,
                      nxc, busy};
  end
endmodule

// File: rtl/adc_ctrl_regs.sv
module adc_ctrl_regs
  import adc_ctrl_pkg::*;
#(
  parameter int NUM_CHAN    = 64,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic              bus_addr,
  input  logic [WORD_W-1:0] bus_wdata,
  output logic [WORD_W-1:0] bus_rdata,
  input  logic              clk_ovf_in,
  input  logic              ext_trig_in,
  output logic              conv_req,
  output logic [CHAN_W-1:0] conv_chan,
  input  logic              conv_ack,
  input  logic [SAMP_W-1:0] conv_data,
  input  logic [CODE_W-1:0] conv_code,
  output logic              irq_done,
  output logic              irq_err
);
  localparam int N_TRIG = 2;

  ctl_cfg_t          cfg_q, cfg_d;
  logic              done_q, err_q, sw_go, busy, capture, start_bad, start_req;
  logic [WORD_W-1:0] res_word;
  logic [N_TRIG-1:0] trig_raw, trig_rise, trig_en;

  assign trig_raw = {ext_trig_in, clk_ovf_in};
  assign trig_en  = {cfg_q.exten, cfg_q.clken};

  for (genvar g = 0; g < N_TRIG; g++) begin : g_trig
    adc_trig_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk  (clk),
      .rst_n(rst_n),
      .din  (trig_raw[g]),
      .rise (trig_rise[g])
    );
  end

  assign start_req = sw_go | |(trig_rise & trig_en);

  adc_ctrl_csr #(.NUM_CHAN(NUM_CHAN)) u_csr (
    .clk      (clk),
    .rst_n    (rst_n),
    .bus_wr   (bus_wr),
    .bus_rd   (bus_rd),
    .bus_addr (bus_addr),
    .bus_wdata(bus_wdata),
    .capture  (capture),
    .start_bad(start_bad),
    .busy     (busy),
    .res_word (res_word),
    .cfg_q    (cfg_q),
    .cfg_d    (cfg_d),
    .done_q   (done_q),
    .err_q    (err_q),
    .sw_go    (sw_go),
    .bus_rdata(bus_rdata)
  );

  adc_conv_seq u_seq (
    .clk      (clk),
    .rst_n    (rst_n),
    .start_req(start_req),
    .cfg_next (cfg_d),
    .conv_ack (conv_ack),
    .conv_data(conv_data),
    .conv_code(conv_code),
    .busy     (busy),
    .capture  (capture),
    .start_bad(start_bad),
    .lat_chan (conv_chan),
    .res_word (res_word)
  );

  assign conv_req = busy;
  assign irq_done = done_q & cfg_q.ie;
  assign irq_err  = err_q & cfg_q.errie;
endmodule

// File: rtl/adc_ctrl_regs_chk.sv
module adc_ctrl_regs_chk #(
  parameter int NUM_CHAN = 64
) (
  input logic        clk,
  input logic        rst_n,
  input logic        bus_wr,
  input logic        bus_rd,
  input logic        bus_addr,
  input logic [15:0] bus_wdata,
  input logic [15:0] bus_rdata,
  input logic        conv_req,
  input logic [5:0]  conv_chan,
  input logic        conv_ack,
  input logic        done_q,
  input logic        err_q
);
  localparam logic [6:0] CH_LIMIT = 7'(NUM_CHAN);

  p_req_ends_r1: assert property (@(posedge clk) disable iff (!rst_n)
    conv_req && conv_ack |=> !conv_req);

  p_restart_err_r2: assert property (@(posedge clk) disable iff (!rst_n)
    bus_wr && !bus_addr && bus_wdata[0] && conv_req && !conv_ack |=> err_q && conv_req);

  p_overrun_r3: assert property (@(posedge clk) disable iff (!rst_n)
    conv_req && conv_ack && done_q && !(bus_rd && bus_addr) |=> err_q);

  p_capture_done_r4: assert property (@(posedge clk) disable iff (!rst_n)
    conv_req && conv_ack |=> done_q);

  p_read_clears_r4: assert property (@(posedge clk) disable iff (!rst_n)
    bus_rd && bus_addr && !bus_wr && !(conv_req && conv_ack) |=> !done_q);

  p_chan_hold_r12: assert property (@(posedge clk) disable iff (!rst_n)
    conv_req && $past(conv_req) |-> $stable(conv_chan));

  p_absent_flag_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_addr |-> bus_rdata[1] == ({1'b0, bus_rdata[13:8]} >= CH_LIMIT));
endmodule

bind adc_ctrl_regs adc_ctrl_regs_chk #(.NUM_CHAN(NUM_CHAN)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .bus_wr   (bus_wr),
  .bus_rd   (bus_rd),
  .bus_addr (bus_addr),
  .bus_wdata(bus_wdata),
  .bus_rdata(bus_rdata),
  .conv_req (conv_req),
  .conv_chan(conv_chan),
  .conv_ack (conv_ack),
  .done_q   (done_q),
  .err_q    (err_q)
);

// File: tb/adc_ctrl_regs_bench.sv
module adc_ctrl_regs_bench;
  localparam int CLK_PERIOD = 10;
  localparam int NCH        = 40;
  localparam int LAT        = 5;
  localparam int WATCHDOG   = 100000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_wr = 1'b0, bus_rd = 1'b0, bus_addr = 1'b0;
  logic [15:0] bus_wdata = '0;
  logic [15:0] bus_rdata;
  logic        clk_ovf_in = 1'b0, ext_trig_in = 1'b0;
  logic        conv_req;
  logic [5:0]  conv_chan;
  logic        conv_ack = 1'b0;
  logic [11:0] conv_data = '0;
  logic [3:0]  conv_code = '0;
  logic        irq_done, irq_err;

  int errors = 0;
  int checks = 0;
  int cyc = 0;
  int cvt_cnt = 0;
  bit finished = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  adc_ctrl_regs #(.NUM_CHAN(NCH)) u_adc_ctrl_regs (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .clk_ovf_in(clk_ovf_in), .ext_trig_in(ext_trig_in),
    .conv_req(conv_req), .conv_chan(conv_chan), .conv_ack(conv_ack),
    .conv_data(conv_data), .conv_code(conv_code),
    .irq_done(irq_done), .irq_err(irq_err)
  );

  // reference model state
  bit m_busy, m_done, m_err, m_errie, m_ie, m_clken, m_exten, m_iden, m_maint;
  bit m_lmaint, m_liden;
  int m_chan, m_lchan, m_res;
  bit [2:0] m_sc, m_se;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_busy = 0; m_done = 0; m_err = 0; m_errie = 0; m_ie = 0;
      m_clken = 0; m_exten = 0; m_iden = 0; m_maint = 0;
      m_lmaint = 0; m_liden = 0; m_chan = 0; m_lchan = 0; m_res = 0;
      m_sc = 0; m_se = 0;
    end else begin
      bit wrc, rdr, cap, st, rc, re, old_busy, old_done;
      int v;
      wrc = bus_wr && !bus_addr;
      rdr = bus_rd && bus_addr;
      cap = conv_ack && m_busy;
      rc = m_sc[1] && !m_sc[2];
      re = m_se[1] && !m_se[2];
      st = (wrc && bus_wdata[0]) || (rc && m_clken) || (re && m_exten);
      old_busy = m_busy; old_done = m_done;
      m_sc = {m_sc[1:0], clk_ovf_in};
      m_se = {m_se[1:0], ext_trig_in};
      if (wrc) begin
        m_err = bus_wdata[15]; m_errie = bus_wdata[14];
        m_chan = int'(bus_wdata[13:8]); m_done = bus_wdata[7];
        m_ie = bus_wdata[6]; m_clken = bus_wdata[5]; m_exten = bus_wdata[4];
        m_iden = bus_wdata[3]; m_maint = bus_wdata[2];
      end
      if (rdr) m_done = 0;
      if (cap) begin
        if (old_done && !rdr) m_err = 1;
        m_done = 1;
        if (m_lmaint && m_lchan == 0) v = 0;
        else if (m_lmaint && m_lchan == 1) v = 4095;
        else v = int'(conv_data);
        if (m_liden) v = v + 4096 * int'(conv_code);
        m_res = v;
        m_busy = 0;
      end
      if (st && old_busy) m_err = 1;
      if (st && !old_busy) begin
        m_busy = 1; m_lchan = m_chan; m_lmaint = m_maint; m_liden = m_iden;
      end
    end
  end

  function automatic logic [15:0] model_ctrl();
    return {m_err, m_errie, 6'(m_chan), m_done, m_ie, m_clken, m_exten,
            m_iden, m_maint, (m_chan >= NCH), m_busy};
  endfunction

  task automatic chk(string req, logic [15:0] act, logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h at cycle %0d", req, act, exp, cyc);
    end
  endtask

  task automatic compare_all();
    if (rst_n) begin
      if (bus_addr) chk("R7 result word", bus_rdata, 16'(m_res));
      else          chk("R11 control word", bus_rdata, model_ctrl());
      chk("R1 conv_req", 16'(conv_req), 16'(m_busy));
      chk("R5 irq_done", 16'(irq_done), 16'(m_done && m_ie));
      chk("R5 irq_err", 16'(irq_err), 16'(m_err && m_errie));
      if (m_busy) chk("R12 conv_chan", 16'(conv_chan), 16'(m_lchan));
    end
  endtask

  task automatic step();
    @(negedge clk);
    cyc++;
    compare_all();
    if (conv_req) begin
      cvt_cnt++;
      if (cvt_cnt == LAT) begin
        conv_ack = 1'b1;
        conv_data = 12'hA00 | 12'(conv_chan);
        conv_code = conv_chan[3:0] ^ 4'h5;
        cvt_cnt = 0;
      end else conv_ack = 1'b0;
    end else begin
      cvt_cnt = 0;
      conv_ack = 1'b0;
    end
  endtask

  task automatic steps(int n);
    for (int i = 0; i < n; i++) step();
  endtask

  task automatic wr_ctl(logic [15:0] d);
    bus_addr = 1'b0; bus_wdata = d; bus_wr = 1'b1;
    step();
    bus_wr = 1'b0;
  endtask

  task automatic rd_res();
    bus_addr = 1'b1; bus_rd = 1'b1;
    step();
    bus_rd = 1'b0;
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  always @(posedge clk) begin
    if (cyc > WATCHDOG) begin
      errors++;
      $display("FAIL watchdog: actual=%0d expected<=%0d cycles", cyc, WATCHDOG);
      finish_run();
    end
  end

  initial begin
    steps(3);
    // R10: reset state
    chk("R10 ctrl", bus_rdata, 16'h0000);
    chk("R10 req/irq", {13'd0, conv_req, irq_done, irq_err}, 16'h0000);
    bus_addr = 1'b1; #1;
    chk("R10 result", bus_rdata, 16'h0000);
    bus_addr = 1'b0;
    rst_n = 1'b1;
    step();

    // R1 R12 R4 R5: plain conversion on channel 3
    wr_ctl(16'h0341);
    chk("R1 busy bit", 16'(bus_rdata[0]), 16'h1);
    chk("R12 chan", 16'(conv_chan), 16'd3);
    wr_ctl(16'h0741); // done stays 0? bit7=0 here; illegal restart also
    chk("R2 err after restart", 16'(bus_rdata[15]), 16'h1);
    chk("R12 chan held", 16'(conv_chan), 16'd3);
    wr_ctl(16'h0740); // clear err, keep ie
    steps(8);
    chk("R4 done set", 16'(bus_rdata[7]), 16'h1);
    chk("R5 irq_done", 16'(irq_done), 16'h1);
    bus_addr = 1'b1; #1;
    chk("R7 untagged", bus_rdata, 16'h0A03);
    rd_res();
    bus_addr = 1'b0; #1;
    chk("R4 done cleared", 16'(bus_rdata[7]), 16'h0);

    // R7: tagged result on channel 9
    wr_ctl(16'h0909);
    steps(8);
    bus_addr = 1'b1; #1;
    chk("R7 tagged", bus_rdata, 16'hCA09);
    rd_res();

    // R6: maintenance values
    wr_ctl(16'h0005); steps(8); bus_addr = 1'b1; #1;
    chk("R6 maint ch0", bus_rdata, 16'h0000); rd_res();
    wr_ctl(16'h0105); steps(8); bus_addr = 1'b1; #1;
    chk("R6 maint ch1", bus_rdata, 16'h0FFF); rd_res();
    wr_ctl(16'h0205); steps(8); bus_addr = 1'b1; #1;
    chk("R6 maint ch2", bus_rdata, 16'h0A02); rd_res();

    // R2 R5: restart with error interrupt enabled
    wr_ctl(16'h4401); steps(2);
    wr_ctl(16'h4401);
    chk("R2 err", 16'(bus_rdata[15]), 16'h1);
    chk("R5 irq_err", 16'(irq_err), 16'h1);
    steps(8); rd_res();
    wr_ctl(16'h0000);
    chk("R11 err cleared", bus_rdata, 16'h0000);

    // R3: overrun (second go keeps done=1)
    wr_ctl(16'h0501); steps(8);
    wr_ctl(16'h0681); steps(8);
    bus_addr = 1'b0; #1;
    chk("R3 overrun err", 16'(bus_rdata[15]), 16'h1);
    rd_res(); wr_ctl(16'h0000);

    // R8 R11: absent channel flag, read-only bit
    wr_ctl(16'h3202);
    chk("R8 absent", bus_rdata, 16'h3202);
    wr_ctl(16'h2702);
    chk("R8 boundary 39", bus_rdata, 16'h2700);
    wr_ctl(16'h2802);
    chk("R8 boundary 40", bus_rdata, 16'h2802);
    wr_ctl(16'h0202);
    chk("R11 bit1 ignored", bus_rdata, 16'h0200);

    // R9: clock-overflow trigger
    wr_ctl(16'h0820);
    clk_ovf_in = 1'b1; step(); step();
    clk_ovf_in = 1'b0;
    chk("R9 not yet", 16'(bus_rdata[0]), 16'h0);
    step();
    chk("R9 clk trig start", 16'(bus_rdata[0]), 16'h1);
    steps(8); rd_res(); bus_addr = 1'b0;
    ext_trig_in = 1'b1; steps(2); ext_trig_in = 1'b0; steps(4);
    chk("R9 ext disabled", 16'(conv_req), 16'h0);
    wr_ctl(16'h0810);
    ext_trig_in = 1'b1; steps(3); ext_trig_in = 1'b0;
    chk("R9 ext trig start", 16'(conv_req), 16'h1);
    steps(8); rd_res();

    // random phase, model compared on every clock
    for (int i = 0; i < 4000; i++) begin
      int r;
      r = $urandom_range(0, 99);
      bus_addr = $urandom_range(0, 1) == 1;
      if (r < 6) begin
        bus_addr = 1'b0;
        bus_wdata = 16'($urandom_range(0, 65535)) & 16'hFFFD;
        bus_wdata[13] = 1'b0;
        bus_wr = 1'b1;
      end else if (r < 16) begin
        bus_addr = 1'b1; bus_rd = 1'b1;
      end
      if ($urandom_range(0, 19) == 0) clk_ovf_in = ~clk_ovf_in;
      if ($urandom_range(0, 19) == 0) ext_trig_in = ~ext_trig_in;
      step();
      bus_wr = 1'b0; bus_rd = 1'b0;
    end
    steps(10);
    finish_run();
  end
endmodule